// File: doc/BRIEF.md
# Hidden One-Time-Programmable Region Access Controller

This block sits between an already decoded command stream and a flash-style memory. It owns a small secret region of 128 one-time-programmable words. When hidden mode is active, it steers qualifying reads and programs to that region instead of the main array. Every word of the region can be written exactly once, and after that it stays locked for good. The usual use is to hold a factory serial number that must not change once the part has shipped.

Commands arrive as single-cycle strobes: enter, exit, read and program. Each strobe comes with a 22-bit word address. The reset input is synchronous and active high, and it stands for both hardware reset and power-up.

While the block is in hidden mode, it qualifies each access against a window. Address bits 14:7 must all be zero, and bits 21:15 are ignored. The outputs respond combinationally in the same cycle as the strobe:
- a hidden-array select;
- the 7-bit local word index;
- a program enable;
- a protection-violation pulse.

Top module: `hidden_otp_gate`

## Requirements
- R1: While `rst` is high, and on every cycle after a reset until an enter strobe has been registered, `hidSel`, `progEn` and `protViol` stay low for any command.
- R2: An enter strobe turns hidden mode on from the next cycle. The mode stays on until an exit strobe is registered, and it is off from the cycle after that. When enter and exit arrive in the same cycle, exit wins.
- R3: In hidden mode, a read or program strobe drives `hidSel` high in the same cycle only when `addr[14:7]` is all zero. The value of `addr[21:15]` has no effect.
- R4: `hidAddr` equals `addr[6:0]` whenever `hidSel` is high, and is zero otherwise.
- R5: In hidden mode, a read whose `addr[14:7]` is nonzero leaves `hidSel`, `progEn` and `protViol` low, so the access goes to the main array.
- R6: In hidden mode, a program to an in-window word that has never been programmed raises `progEn` in that cycle. From the next cycle on, that word is locked.
- R7: A program to a locked word raises `protViol` for that cycle only and keeps `progEn` low. `progEn` and `protViol` are never high together.
- R8: In hidden mode, a program whose `addr[14:7]` is nonzero raises `protViol` and keeps `progEn` low. It locks no word.
- R9: Lock state survives `rst`. After a reset and a new enter, a word programmed earlier still gives `protViol`.
- R10: Outside hidden mode, a read or program strobe never raises `hidSel`, `progEn` or `protViol`, and it locks no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset / power-up |
| cmdEnter | input | 1 | Enter-hidden-mode strobe |
| cmdExit | input | 1 | Exit-hidden-mode strobe |
| cmdRead | input | 1 | Read strobe |
| cmdProgram | input | 1 | Program strobe |
| addr | input | 22 | Word address of the command |
| hidSel | output | 1 | Access targets the hidden region |
| hidAddr | output | 7 | Local word index in the hidden region |
| progEn | output | 1 | Program the addressed hidden word |
| protViol | output | 1 | Rejected hidden program, one cycle |

## Verification
A wrong mode bit shows up as a wrong `hidSel` on the very first access after the faulty enter, exit or reset edge. A wrong window decode shows up as soon as a read sets any of bits 14:7, or varies bits 21:15. A lost or spurious lock bit stays invisible until that same word is programmed again. It then shows in that strobe's cycle as a swapped `progEn`/`protViol` pair. For that reason the bench programs all 128 words twice, and programs one word again after a reset.

// File: rtl/otp_pkg.sv
package otp_pkg;
  // strobes from the mode control to the address/lock datapath
  typedef struct packed {
    logic hidMode;
    logic accRead;
    logic accProg;
  } ctlStrobes_t;
endpackage

// File: rtl/otp_ctl.sv
module otp_ctl
  import otp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmdEnter,
  input  logic        cmdExit,
  input  logic        cmdRead,
  input  logic        cmdProgram,
  output ctlStrobes_t strobes
);
  logic modeQ;

  // exit has priority over enter; reset clears the mode
  always_ff @(posedge clk) begin
    if (rst)           modeQ <= 1'b0;
    else if (cmdExit)  modeQ <= 1'b0;
    else if (cmdEnter) modeQ <= 1'b1;
  end

  always_comb begin
    strobes.hidMode = modeQ & ~rst;
    strobes.accRead = cmdRead & ~rst;
    strobes.accProg = cmdProgram & ~rst;
  end
endmodule

// File: rtl/otp_dp.sv
module otp_dp
  import otp_pkg::*;
#(
  parameter int IDX_W   = 7,
  parameter int WIN_TOP = 14,
  localparam int DEPTH  = 1 << IDX_W
) (
  input  logic               clk,
  input  ctlStrobes_t        strobes,
  input  logic [WIN_TOP:0]   addrLow,
  output logic               hidSel,
  output logic [IDX_W-1:0]   hidAddr,
  output logic               progEn,
  output logic               protViol
);
  // one lock bit per word; cleared only at power-up, never by rst
  logic [DEPTH-1:0] lockBits = '0;
  logic [IDX_W-1:0] wordIdx;
  logic             winHit;
  logic             anyAcc;
  logic             wordLocked;

  assign wordIdx    = addrLow[IDX_W-1:0];
  assign winHit     = (addrLow[WIN_TOP:IDX_W] == '0);
  assign anyAcc     = strobes.accRead | strobes.accProg;
  assign wordLocked = lockBits[wordIdx];

  always_comb begin
    hidSel   = strobes.hidMode & anyAcc & winHit;
    hidAddr  = hidSel ? wordIdx : '0;
    progEn   = strobes.hidMode & strobes.accProg & winHit & ~wordLocked;
    protViol = strobes.hidMode & strobes.accProg & (~winHit | wordLocked);
  end

  always_ff @(posedge clk) begin
    if (progEn) lockBits[wordIdx] <= 1'b1;
  end
endmodule

// File: rtl/hidden_otp_gate.sv
module hidden_otp_gate
  import otp_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int IDX_W   = 7,
  parameter int WIN_TOP = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdEnter,
  input  logic              cmdExit,
  input  logic              cmdRead,
  input  logic              cmdProgram,
  input  logic [ADDR_W-1:0] addr,
  output logic              hidSel,
  output logic [IDX_W-1:0]  hidAddr,
  output logic              progEn,
  output logic              protViol
);
  ctlStrobes_t strobes;
  logic        unusedTopBits;

  // bits above the window are don't-care
  assign unusedTopBits = ^addr[ADDR_W-1:WIN_TOP+1];

  otp_ctl uCtl (
    .clk(clk), .rst(rst), .cmdEnter(cmdEnter), .cmdExit(cmdExit),
    .cmdRead(cmdRead), .cmdProgram(cmdProgram), .strobes(strobes)
  );

  otp_dp #(.IDX_W(IDX_W), .WIN_TOP(WIN_TOP)) uDp (
    .clk(clk), .strobes(strobes), .addrLow(addr[WIN_TOP:0]),
    .hidSel(hidSel), .hidAddr(hidAddr), .progEn(progEn), .protViol(protViol)
  );
endmodule

// File: rtl/otp_chk.sv
module otp_chk #(
  parameter int ADDR_W  = 22,
  parameter int IDX_W   = 7,
  parameter int WIN_TOP = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              cmdExit,
  input logic              cmdRead,
  input logic              cmdProgram,
  input logic [ADDR_W-1:0] addr,
  input logic              hidSel,
  input logic [IDX_W-1:0]  hidAddr,
  input logic              progEn,
  input logic              protViol
);
  AST_PROG_VIOL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(progEn && protViol)); // R7

  AST_SEL_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    hidSel |-> (addr[WIN_TOP:IDX_W] == '0) && (cmdRead || cmdProgram)); // R3

  AST_VIOL_NEEDS_PROG: assert property (@(posedge clk) disable iff (rst)
    protViol |-> cmdProgram); // R8

  AST_EXIT_LEAVES_MODE: assert property (@(posedge clk) disable iff (rst)
    cmdExit |=> !hidSel && !progEn && !protViol); // R2

  AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    !hidSel |-> hidAddr == '0); // R4

  AST_SEL_ADDR_MATCH: assert property (@(posedge clk) disable iff (rst)
    hidSel |-> hidAddr == addr[IDX_W-1:0]); // R4
endmodule

bind hidden_otp_gate otp_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WIN_TOP(WIN_TOP)) uChk (
  .clk(clk), .rst(rst), .cmdExit(cmdExit), .cmdRead(cmdRead),
  .cmdProgram(cmdProgram), .addr(addr), .hidSel(hidSel), .hidAddr(hidAddr),
  .progEn(progEn), .protViol(protViol)
);

// File: tb/tb_hidden_otp_gate.sv
module tb_hidden_otp_gate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdEnter = 1'b0, cmdExit = 1'b0, cmdRead = 1'b0, cmdProgram = 1'b0;
  logic [21:0] addr = '0;
  logic        hidSel, progEn, protViol;
  logic [6:0]  hidAddr;

  int total = 0;
  int bad = 0;
  bit modeM = 1'b0;
  bit lockM [128];

  always #10 clk = ~clk;

  hidden_otp_gate dut (
    .clk(clk), .rst(rst), .cmdEnter(cmdEnter), .cmdExit(cmdExit),
    .cmdRead(cmdRead), .cmdProgram(cmdProgram), .addr(addr),
    .hidSel(hidSel), .hidAddr(hidAddr), .progEn(progEn), .protViol(protViol)
  );

  task automatic check(string req, logic [9:0] got, logic [9:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h addr=%h", req, got, exp, addr);
    end
  endtask

  // one access; outputs are combinational, sampled 2 ns after driving
  task automatic access(bit isProg, logic [21:0] a, string req);
    bit hit, sel, pe, pv;
    int idx;
    idx = int'(a[6:0]);
    hit = modeM && (a[14:7] == 8'd0);
    sel = hit;
    pe  = isProg && hit && !lockM[idx];
    pv  = isProg && modeM && (!hit || lockM[idx]);
    @(negedge clk);
    addr = a; cmdProgram = isProg; cmdRead = !isProg;
    #2;
    check(req, {hidSel, hidAddr, progEn, protViol},
          {sel, (sel ? a[6:0] : 7'd0), pe, pv});
    @(posedge clk); #1;
    cmdProgram = 1'b0; cmdRead = 1'b0;
    if (pe) lockM[idx] = 1'b1;
  endtask

  task automatic modeCmd(bit en, bit ex);
    @(negedge clk);
    cmdEnter = en; cmdExit = ex;
    @(posedge clk); #1;
    cmdEnter = 1'b0; cmdExit = 1'b0;
    if (ex) modeM = 1'b0; else if (en) modeM = 1'b1;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    cmdProgram = 1'b1; addr = '0;
    #2; check("R1 during rst", {hidSel, hidAddr, progEn, protViol}, 10'd0);
    @(posedge clk); #1; rst = 1'b0; cmdProgram = 1'b0;
    modeM = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    foreach (lockM[i]) lockM[i] = 1'b0;
    repeat (2) @(posedge clk);
    doReset();
    // R1: after reset, no hidden access
    access(1'b0, 22'h0, "R1 read after reset");
    access(1'b1, 22'h5, "R1 prog after reset");
    // R10: main-mode commands over a range of addresses
    for (int i = 0; i < 16; i++) begin
      access(1'b0, 22'(i * 37), "R10 main read");
      access(1'b1, 22'(i * 3), "R10 main prog");
    end
    // R2: simultaneous enter+exit keeps mode off
    modeCmd(1'b1, 1'b1);
    access(1'b0, 22'h1, "R2 exit wins");
    modeCmd(1'b1, 1'b0);
    // R3/R4: every word readable, top bits varied
    for (int i = 0; i < 128; i++)
      access(1'b0, {7'(i * 5 + 1), 8'd0, 7'(i)}, "R3 R4 window read");
    // R5: each window bit alone sends the read to main
    for (int b = 7; b <= 14; b++)
      access(1'b0, 22'(1 << b) | 22'h12, "R5 out-of-window read");
    // R8: out-of-window programs
    for (int b = 7; b <= 14; b++)
      access(1'b1, 22'(1 << b) | 22'h22, "R8 out-of-window prog");
    access(1'b1, 22'h22, "R8 word not locked by rejected prog");
    // R6/R7: program all words, then again
    for (int i = 0; i < 128; i++)
      access(1'b1, {7'(i), 8'd0, 7'(i)}, "R6 first program");
    for (int i = 0; i < 128; i++)
      access(1'b1, {7'(127 - i), 8'd0, 7'(i)}, "R7 reprogram locked");
    for (int i = 0; i < 8; i++)
      access(1'b0, 22'(i * 9), "R7 locked word still readable");
    // R2: exit clears mode
    modeCmd(1'b0, 1'b1);
    access(1'b0, 22'h3, "R2 read after exit");
    access(1'b1, 22'h3, "R2 prog after exit");
    // R9: locks survive reset
    modeCmd(1'b1, 1'b0);
    doReset();
    access(1'b0, 22'h3, "R1 mode cleared by reset");
    modeCmd(1'b1, 1'b0);
    access(1'b1, 22'h3, "R9 lock kept over reset");
    access(1'b1, 22'h40, "R9 lock kept over reset");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule